// File: doc/BRIEF.md
# Fast-Lock Window Sequencer for a Synthesizer Main Loop

After a new frequency word is loaded, this block opens a timed fast-lock window for the main loop of a frequency synthesizer. A rising edge on the load strobe arms a down-counter with an 8-bit duration. The duration is built from two 4-bit nibbles and counts reference-divider output ticks. While the window is open, the block sets the scale codes for the main charge pump and the auxiliary integral charge pump. When the window closes, the main pump returns to its nominal scale and the integral pump is either switched off or parked in standby, depending on a policy bit.

The boost exponent is `cl + 1`. During the window, the main pump multiplier is `1 + 2^(cl+1)` and the integral pump multiplier is `2^(cl+1) * ck`. Both multipliers are also applied to the 8-bit nominal current factor `cn`, whose LSB weight is 1/256 of full scale. This gives scale codes the pump DACs can use directly. Two flags report when a supplied base-current code, multiplied by the active multiplier, would go above the main-pump or integral-pump current ceiling.

Top module: `spdup_timer_ctrl`

## Requirements
- R1: While `rst` is high and on the cycle after it, `win_active`, `main_sat` and `int_sat` are 0, `main_mult` is 1, `int_mult` is 0, and `int_state` follows the standby policy for a closed window.
- R2: A rising edge of `load_strobe` seen at a clock edge loads the duration G = {`dur_hi`,`dur_lo`} (`dur_hi` is bits 7:4). If G is nonzero, `win_active` is 1 from that edge onward.
- R3: While the window is open, each clock edge with `ref_tick` high counts down one unit. `win_active` falls on the edge that takes the G-th tick. Ticks while the window is closed have no effect.
- R4: A load edge with G = 0 does not open a window. `win_active` stays 0.
- R5: A load edge during an open window reloads the count with the current G and restarts the full window.
- R6: `main_mult` is 1 + 2^(`cl`+1) while the window is open and 1 otherwise. `main_scale` = `cn` * `main_mult`.
- R7: `int_mult` is 2^(`cl`+1) * `ck` while the window is open and 0 otherwise. `int_scale` = `cn` * `int_mult`.
- R8: `int_state` encoding: 2'b10 = on while the window is open. When the window is closed it is 2'b01 = standby if `stby_keep` is 1, and 2'b00 = off if `stby_keep` is 0.
- R9: `main_sat` = window open and `base_code` * `main_mult` > MAIN_LIMIT (default 1200). `int_sat` = window open and `base_code` * `int_mult` > INT_LIMIT (default 2400). Both are 0 while the window is closed.
- R10: The window length is fixed at the load edge. Changing `dur_hi`/`dur_lo` afterwards, or holding `load_strobe` high, neither stretches nor restarts the window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| load_strobe | input | 1 | Frequency-word load strobe; its rising edge starts a window |
| ref_tick | input | 1 | One-cycle pulse per reference-divider output cycle |
| dur_hi | input | 4 | Upper nibble of window duration |
| dur_lo | input | 4 | Lower nibble of window duration |
| cl | input | 2 | Boost exponent select (power is cl+1) |
| ck | input | 4 | Integral pump acceleration factor |
| cn | input | 8 | Nominal main pump current factor (LSB = 1/256) |
| stby_keep | input | 1 | 1: integral pump in standby outside window; 0: off |
| base_code | input | 8 | Base current code used for ceiling checks |
| win_active | output | 1 | Fast-lock window open |
| main_mult | output | 5 | Main pump multiplier |
| int_mult | output | 8 | Integral pump multiplier |
| main_scale | output | 13 | cn times main multiplier |
| int_scale | output | 16 | cn times integral multiplier |
| int_state | output | 2 | Integral pump state: 00 off, 01 standby, 10 on |
| main_sat | output | 1 | Boosted main current exceeds ceiling |
| int_sat | output | 1 | Integral current exceeds ceiling |

## Verification
The hardest case to reach from the ports is a reload in the middle of a window. The strobe has to rise while the counter is partway down, and the restart must then be told apart from the window simply continuing. The stimulus opens a window, consumes some of its ticks, and raises the strobe again. It then counts the ticks until the flag falls and checks that the count equals a full G, not the remainder. A held-high strobe and a duration changed mid-window are driven the same way, to show that only a fresh edge reloads the counter.

// File: rtl/spdup_pkg.sv
package spdup_pkg;

    localparam int NIB_W_DEF  = 4;
    localparam int CL_W_DEF   = 2;
    localparam int CK_W_DEF   = 4;
    localparam int CN_W_DEF   = 8;
    localparam int BASE_W_DEF = 8;

    typedef enum logic [1:0] {
        IPUMP_OFF  = 2'b00,
        IPUMP_STBY = 2'b01,
        IPUMP_ON   = 2'b10
    } ipump_state_e;

    typedef struct packed {
        logic         open;
        logic         keep_stby;
    } win_ctl_t;

    function automatic ipump_state_e ipump_pick(input win_ctl_t c);
        if (c.open)
            return IPUMP_ON;
        else if (c.keep_stby)
            return IPUMP_STBY;
        else
            return IPUMP_OFF;
    endfunction

endpackage

// File: rtl/spdup_edge.sv
module spdup_edge (
    input  logic clk,
    input  logic rst,
    input  logic lvl,
    output logic rise
);
    logic lvl_q;

    always_ff @(posedge clk) begin
        if (rst)
            lvl_q <= 1'b0;
        else
            lvl_q <= lvl;
    end

    assign rise = lvl & ~lvl_q;
endmodule

// File: rtl/spdup_window.sv
module spdup_window #(
    parameter int G_W = 8
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           start,
    input  logic           tick,
    input  logic [G_W-1:0] g,
    output logic           open
);
    localparam logic [G_W-1:0] ONE  = {{(G_W-1){1'b0}}, 1'b1};
    localparam logic [G_W-1:0] ZERO = '0;

    logic [G_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt  <= ZERO;
            open <= 1'b0;
        end else if (start) begin
            cnt  <= g;
            open <= (g != ZERO);
        end else if (open && tick) begin
            cnt  <= cnt - ONE;
            open <= (cnt != ONE);
        end
    end
endmodule

// File: rtl/spdup_scale.sv
module spdup_scale
    import spdup_pkg::*;
#(
    parameter int CL_W = 2,
    parameter int CK_W = 4,
    parameter int CN_W = 8,
    parameter int MM_W = (1 << CL_W) + 1,
    parameter int IM_W = (1 << CL_W) + CK_W
) (
    input  logic              open,
    input  logic              keep_stby,
    input  logic [CL_W-1:0]   cl,
    input  logic [CK_W-1:0]   ck,
    input  logic [CN_W-1:0]   cn,
    output logic [MM_W-1:0]   main_mult,
    output logic [IM_W-1:0]   int_mult,
    output logic [CN_W+MM_W-1:0] main_scale,
    output logic [CN_W+IM_W-1:0] int_scale,
    output logic [1:0]        state
);
    localparam int SH_W = CL_W + 1;
    localparam int MS_W = CN_W + MM_W;
    localparam int IS_W = CN_W + IM_W;

    logic [SH_W-1:0] shamt;
    logic [MM_W-1:0] pow_m;
    logic [IM_W-1:0] ck_sh;
    win_ctl_t        ctl;

    always_comb begin
        shamt = {1'b0, cl} + {{CL_W{1'b0}}, 1'b1};
        pow_m = {{(MM_W-1){1'b0}}, 1'b1} << shamt;
        ck_sh = {{(IM_W-CK_W){1'b0}}, ck} << shamt;

        if (open) begin
            main_mult = pow_m + {{(MM_W-1){1'b0}}, 1'b1};
            int_mult  = ck_sh;
        end else begin
            main_mult = {{(MM_W-1){1'b0}}, 1'b1};
            int_mult  = '0;
        end

        main_scale = {{MM_W{1'b0}}, cn} * {{CN_W{1'b0}}, main_mult};
        int_scale  = {{IM_W{1'b0}}, cn} * {{CN_W{1'b0}}, int_mult};

        ctl.open      = open;
        ctl.keep_stby = keep_stby;
        state         = ipump_pick(ctl);
    end

    logic unused_w;
    assign unused_w = (MS_W == 0) | (IS_W == 0);
endmodule

// File: rtl/spdup_limit.sv
module spdup_limit #(
    parameter int A_W   = 8,
    parameter int B_W   = 5,
    parameter int LIMIT = 1200
) (
    input  logic           en,
    input  logic [A_W-1:0] a,
    input  logic [B_W-1:0] b,
    output logic           over
);
    localparam int P_W = A_W + B_W + 1;

    logic [P_W-1:0] prod;
    logic [P_W-1:0] lim;

    always_comb begin
        prod = {{(B_W+1){1'b0}}, a} * {{(A_W+1){1'b0}}, b};
        lim  = P_W'(LIMIT);
        over = en && (prod > lim);
    end
endmodule

// File: rtl/spdup_timer_ctrl.sv
module spdup_timer_ctrl
    import spdup_pkg::*;
#(
    parameter int NIB_W      = NIB_W_DEF,
    parameter int CL_W       = CL_W_DEF,
    parameter int CK_W       = CK_W_DEF,
    parameter int CN_W       = CN_W_DEF,
    parameter int BASE_W     = BASE_W_DEF,
    parameter int MAIN_LIMIT = 1200,
    parameter int INT_LIMIT  = 2400,
    parameter int MM_W       = (1 << CL_W) + 1,
    parameter int IM_W       = (1 << CL_W) + CK_W
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  load_strobe,
    input  logic                  ref_tick,
    input  logic [NIB_W-1:0]      dur_hi,
    input  logic [NIB_W-1:0]      dur_lo,
    input  logic [CL_W-1:0]       cl,
    input  logic [CK_W-1:0]       ck,
    input  logic [CN_W-1:0]       cn,
    input  logic                  stby_keep,
    input  logic [BASE_W-1:0]     base_code,
    output logic                  win_active,
    output logic [MM_W-1:0]       main_mult,
    output logic [IM_W-1:0]       int_mult,
    output logic [CN_W+MM_W-1:0]  main_scale,
    output logic [CN_W+IM_W-1:0]  int_scale,
    output logic [1:0]            int_state,
    output logic                  main_sat,
    output logic                  int_sat
);
    localparam int G_W = 2 * NIB_W;

    logic           load_rise;
    logic [G_W-1:0] dur_g;

    assign dur_g = {dur_hi, dur_lo};

    spdup_edge u_edge (
        .clk  (clk),
        .rst  (rst),
        .lvl  (load_strobe),
        .rise (load_rise)
    );

    spdup_window #(.G_W(G_W)) u_win (
        .clk   (clk),
        .rst   (rst),
        .start (load_rise),
        .tick  (ref_tick),
        .g     (dur_g),
        .open  (win_active)
    );

    spdup_scale #(
        .CL_W (CL_W),
        .CK_W (CK_W),
        .CN_W (CN_W),
        .MM_W (MM_W),
        .IM_W (IM_W)
    ) u_scale (
        .open       (win_active),
        .keep_stby  (stby_keep),
        .cl         (cl),
        .ck         (ck),
        .cn         (cn),
        .main_mult  (main_mult),
        .int_mult   (int_mult),
        .main_scale (main_scale),
        .int_scale  (int_scale),
        .state      (int_state)
    );

    for (genvar k = 0; k < 2; k++) begin : g_lim
        localparam int W   = (k == 0) ? MM_W : IM_W;
        localparam int LIM = (k == 0) ? MAIN_LIMIT : INT_LIMIT;
        logic [W-1:0] mult_k;
        logic         over_k;
        if (k == 0) begin : g_m
            assign mult_k = main_mult;
            assign main_sat = over_k;
        end else begin : g_i
            assign mult_k = int_mult;
            assign int_sat = over_k;
        end
        spdup_limit #(.A_W(BASE_W), .B_W(W), .LIMIT(LIM)) u_lim (
            .en   (win_active),
            .a    (base_code),
            .b    (mult_k),
            .over (over_k)
        );
    end
endmodule

// File: rtl/spdup_chk.sv
module spdup_chk #(
    parameter int NIB_W = 4,
    parameter int MM_W  = 5,
    parameter int IM_W  = 8
) (
    input logic             clk,
    input logic             rst,
    input logic             load_strobe,
    input logic             ref_tick,
    input logic [NIB_W-1:0] dur_hi,
    input logic [NIB_W-1:0] dur_lo,
    input logic             stby_keep,
    input logic             win_active,
    input logic [MM_W-1:0]  main_mult,
    input logic [IM_W-1:0]  int_mult,
    input logic [1:0]       int_state,
    input logic             main_sat,
    input logic             int_sat
);
    logic g_zero;
    assign g_zero = ({dur_hi, dur_lo} == '0);

    assert_open_R2: assert property (@(posedge clk) disable iff (rst)
        (load_strobe && !$past(load_strobe) && !g_zero) |=> win_active);

    assert_zero_len_R4: assert property (@(posedge clk) disable iff (rst)
        (load_strobe && !$past(load_strobe) && g_zero) |=> !win_active);

    assert_hold_R3: assert property (@(posedge clk) disable iff (rst)
        (win_active && !ref_tick && !(load_strobe && !$past(load_strobe))) |=> win_active);

    assert_no_open_R3: assert property (@(posedge clk) disable iff (rst)
        (!win_active && !(load_strobe && !$past(load_strobe))) |=> !win_active);

    assert_idle_mult_R6: assert property (@(posedge clk) disable iff (rst)
        !win_active |-> (main_mult == MM_W'(1) && int_mult == '0));

    assert_state_R8: assert property (@(posedge clk) disable iff (rst)
        (win_active |-> int_state == 2'b10) and
        (!win_active |-> int_state == {1'b0, stby_keep}));

    assert_sat_idle_R9: assert property (@(posedge clk) disable iff (rst)
        !win_active |-> (!main_sat && !int_sat));
endmodule

bind spdup_timer_ctrl spdup_chk #(
    .NIB_W (NIB_W),
    .MM_W  (MM_W),
    .IM_W  (IM_W)
) u_chk (
    .clk         (clk),
    .rst         (rst),
    .load_strobe (load_strobe),
    .ref_tick    (ref_tick),
    .dur_hi      (dur_hi),
    .dur_lo      (dur_lo),
    .stby_keep   (stby_keep),
    .win_active  (win_active),
    .main_mult   (main_mult),
    .int_mult    (int_mult),
    .int_state   (int_state),
    .main_sat    (main_sat),
    .int_sat     (int_sat)
);

// File: tb/sim_spdup_timer_ctrl.sv
module sim_spdup_timer_ctrl;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        load_strobe = 1'b0;
    logic        ref_tick = 1'b0;
    logic [3:0]  dur_hi = '0;
    logic [3:0]  dur_lo = '0;
    logic [1:0]  cl = '0;
    logic [3:0]  ck = '0;
    logic [7:0]  cn = '0;
    logic        stby_keep = 1'b1;
    logic [7:0]  base_code = '0;
    logic        win_active;
    logic [4:0]  main_mult;
    logic [7:0]  int_mult;
    logic [12:0] main_scale;
    logic [15:0] int_scale;
    logic [1:0]  int_state;
    logic        main_sat;
    logic        int_sat;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    spdup_timer_ctrl u0 (
        .clk(clk), .rst(rst), .load_strobe(load_strobe), .ref_tick(ref_tick),
        .dur_hi(dur_hi), .dur_lo(dur_lo), .cl(cl), .ck(ck), .cn(cn),
        .stby_keep(stby_keep), .base_code(base_code), .win_active(win_active),
        .main_mult(main_mult), .int_mult(int_mult), .main_scale(main_scale),
        .int_scale(int_scale), .int_state(int_state), .main_sat(main_sat),
        .int_sat(int_sat)
    );

    // fields: cl[22:21] ck[20:17] cn[16:9] stby[8] base[7:0]
    localparam int NV = 8;
    localparam logic [22:0] VEC [0:NV-1] = '{
        {2'd0, 4'd1,  8'd128, 1'b0, 8'd10},
        {2'd1, 4'd3,  8'd200, 1'b1, 8'd50},
        {2'd2, 4'd7,  8'd255, 1'b0, 8'd20},
        {2'd3, 4'd15, 8'd64,  1'b1, 8'd10},
        {2'd3, 4'd15, 8'd1,   1'b0, 8'd11},
        {2'd3, 4'd2,  8'd100, 1'b1, 8'd70},
        {2'd3, 4'd2,  8'd100, 1'b0, 8'd71},
        {2'd2, 4'd0,  8'd0,   1'b1, 8'd255}
    };

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic pulse_load();
        @(negedge clk) load_strobe = 1'b1;
        @(negedge clk) load_strobe = 1'b0;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk) ref_tick = 1'b1;
        end
        @(negedge clk) ref_tick = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    initial begin
        #(8 * 150000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        idle(3);
        // R1: reset state, standby policy
        check("R1 active", int'(win_active), 0);
        check("R1 main_mult", int'(main_mult), 1);
        check("R1 int_mult", int'(int_mult), 0);
        check("R1 int_state", int'(int_state), 1);
        check("R1 sat", int'({main_sat, int_sat}), 0);
        rst = 1'b0;
        idle(1);
        check("R1 after release", int'(win_active), 0);
        stby_keep = 1'b0;
        idle(1);
        check("R8 off when closed", int'(int_state), 0);

        // table walk: R6 R7 R8 R9
        for (int v = 0; v < NV; v++) begin
            int em, ei, ems, eis, es, ees;
            {cl, ck, cn, stby_keep, base_code} = VEC[v];
            dur_hi = 4'd0; dur_lo = 4'd2;
            em = 1 + (1 << (int'(cl) + 1));
            ei = (1 << (int'(cl) + 1)) * int'(ck);
            ems = int'(cn) * em;
            eis = int'(cn) * ei;
            es = (int'(base_code) * em > 1200) ? 1 : 0;
            ees = (int'(base_code) * ei > 2400) ? 1 : 0;
            pulse_load();
            check("R2 opened", int'(win_active), 1);
            check("R6 main_mult", int'(main_mult), em);
            check("R6 main_scale", int'(main_scale), ems);
            check("R7 int_mult", int'(int_mult), ei);
            check("R7 int_scale", int'(int_scale), eis);
            check("R8 on", int'(int_state), 2);
            check("R9 main_sat", int'(main_sat), es);
            check("R9 int_sat", int'(int_sat), ees);
            ticks(2);
            check("R3 closed", int'(win_active), 0);
            check("R6 idle mult", int'(main_mult), 1);
            check("R7 idle int", int'(int_mult), 0);
            check("R8 closed state", int'(int_state), stby_keep ? 1 : 0);
            check("R9 idle sat", int'({main_sat, int_sat}), 0);
        end

        // R3: idle ticks ignored, exact length G=5
        cl = 2'd1; ck = 4'd1; cn = 8'd10; base_code = 8'd1; stby_keep = 1'b0;
        ticks(6);
        check("R3 idle ticks", int'(win_active), 0);
        dur_hi = 4'd0; dur_lo = 4'd5;
        pulse_load();
        idle(3);
        check("R3 no tick hold", int'(win_active), 1);
        ticks(4);
        check("R3 before last", int'(win_active), 1);
        ticks(1);
        check("R3 at last", int'(win_active), 0);
        ticks(3);
        check("R3 stays closed", int'(win_active), 0);

        // R2: nibble order, G = 0x12 = 18
        dur_hi = 4'd1; dur_lo = 4'd2;
        pulse_load();
        ticks(17);
        check("R2 nibble order pre", int'(win_active), 1);
        ticks(1);
        check("R2 nibble order end", int'(win_active), 0);

        // R4: zero duration
        dur_hi = 4'd0; dur_lo = 4'd0;
        pulse_load();
        check("R4 no window", int'(win_active), 0);
        idle(2);
        check("R4 still none", int'(win_active), 0);

        // R5: retrigger mid-window
        dur_lo = 4'd4;
        pulse_load();
        ticks(2);
        pulse_load();
        ticks(3);
        check("R5 restarted", int'(win_active), 1);
        ticks(1);
        check("R5 full length", int'(win_active), 0);

        // R10: duration change after load
        dur_lo = 4'd3;
        pulse_load();
        dur_hi = 4'd0; dur_lo = 4'd10;
        ticks(3);
        check("R10 latched length", int'(win_active), 0);

        // R10: strobe held high does not restart
        dur_lo = 4'd3;
        @(negedge clk) load_strobe = 1'b1;
        @(negedge clk);
        ticks(3);
        check("R10 held strobe closes", int'(win_active), 0);
        idle(4);
        check("R10 held strobe no restart", int'(win_active), 0);
        load_strobe = 1'b0;
        idle(1);

        // R9: saturation boundary on main pump
        cl = 2'd3; ck = 4'd0; base_code = 8'd70; dur_lo = 4'd2;
        pulse_load();
        check("R9 1190 under", int'(main_sat), 0);
        base_code = 8'd71;
        @(negedge clk);
        check("R9 1207 over", int'(main_sat), 1);
        ticks(2);
        check("R9 cleared", int'(main_sat), 0);

        // R1: reset mid-window
        pulse_load();
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        check("R1 reset closes", int'(win_active), 0);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule